// File: doc/BRIEF.md
# Smart-Card T=0 Parity-Error NACK Controller

This block decides, for each character received over a half-duplex smart-card link running the T=0 character protocol, whether the receiver must signal a parity error back to the card. It then times that signal. When a character arrives with bad parity, the block raises a request to pull the shared I/O line low during the guard period. The card takes this request as a NACK and repeats the character. The receiver front end supplies a one-cycle strobe per character together with a parity-error flag. The line driver acts on the pull-low request.

In limited-retry mode the block counts back-to-back parity errors. While the count is below a programmed maximum, each error still gets a NACK. When an error arrives with the count already at that maximum, the NACK is withheld and a sticky iteration flag is raised for the host to see. A suppress input turns NACK generation off entirely. A clear pulse resets the flag and the error counter.

The elementary time unit is fixed at build time as a number of clock cycles, `ETU_CLKS`. The strobe is expected at the clock cycle in which the parity bit has been sampled.

Top module: `t0_nack_ctrl`

## Requirements
- R1: While `inhibitNack` is 1 when a character is accepted, `nackDrive` never rises for that character. Counting and the flag still follow R2 to R4.
- R2: With `limitEn` at 0, every accepted character with `parityErr` at 1 (and `inhibitNack` at 0) produces a NACK. `errCount` is 0 after every accepted character.
- R3: With `limitEn` at 1, an accepted bad character that finds `errCount` below `maxIter` produces a NACK and increments `errCount` by one.
- R4: With `limitEn` at 1, an accepted bad character that finds `errCount` at or above `maxIter` produces no NACK, sets `iterFlag` and leaves `errCount` unchanged. With `maxIter` at 0, the first error is handled this way.
- R5: An accepted character with good parity clears `errCount` and leaves `iterFlag` unchanged.
- R6: `iterFlag` stays at 1 until `iterClr` is pulsed. The pulse clears both `iterFlag` and `errCount` at the next edge. A character strobe in the same cycle as `iterClr` is dropped: no NACK, no count.
- R7: `nackDrive` rises exactly `ETU_CLKS/2` cycles after the edge that samples the strobe. It stays high for `ETU_CLKS` cycles when `nackLong` was 0 at the strobe, or for `2*ETU_CLKS` cycles when it was 1.
- R8: A character strobe that arrives while a NACK is pending or being driven is ignored. It changes neither `errCount` nor `iterFlag` and does not extend or restart the NACK.
- R9: After reset `nackDrive`, `iterFlag` and `errCount` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | One-cycle strobe: a character has been received |
| parityErr | input | 1 | Parity of the strobed character was wrong |
| inhibitNack | input | 1 | Suppress all NACK generation |
| limitEn | input | 1 | Enable counting of successive errors and the retry limit |
| maxIter | input | CNT_W | Maximum number of NACKed successive errors |
| nackLong | input | 1 | NACK length select: 0 gives one time unit, 1 gives two |
| iterClr | input | 1 | Pulse: clear the iteration flag and error counter |
| nackDrive | output | 1 | Request to pull the I/O line low |
| iterFlag | output | 1 | Sticky flag: retry limit exceeded |
| errCount | output | CNT_W | Current count of successive parity errors |

## Verification
Directed sequences walk the counter up to a limit of two and one step past it, then show that a good character clears the count but not the flag. They also cover a zero limit, which withholds the very first NACK. Further directed cases cover suppression, a clear that collides with a strobe, and a strobe that lands inside a pending NACK window. The first three separate the "below limit" and "at limit" branches. The last two show which input wins a same-cycle conflict. Random runs mix the suppress bit, the mode bit, the limit and the length select with error-heavy parity streams. They compare the start cycle and the width of every NACK pulse, as well as the count and the flag, against a bench model. This shows that the timing does not depend on the counting path.

// File: rtl/t0nack_pkg.sv
package t0nack_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_DRIVE = 2'd2
  } seqState_e;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic flagSet;
    logic flagClr;
    logic loadDelay;
    logic loadLen;
    logic latchLong;
  } dpStrobes_t;

endpackage

// File: rtl/t0nack_datapath.sv
module t0nack_datapath
  import t0nack_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int ETU_CLKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       stb,
  input  logic             nackLong,
  input  logic [CNT_W-1:0] maxIter,
  output logic [CNT_W-1:0] errCount,
  output logic             iterFlag,
  output logic             cntAtLimit,
  output logic             timerDone
);

  localparam int HALF_ETU = ETU_CLKS / 2;
  localparam int TMR_W    = $clog2(2 * ETU_CLKS);
  localparam logic [TMR_W-1:0] DELAY_LOAD = TMR_W'(HALF_ETU - 1);
  localparam logic [TMR_W-1:0] SHORT_LOAD = TMR_W'(ETU_CLKS - 1);
  localparam logic [TMR_W-1:0] LONG_LOAD  = TMR_W'(2 * ETU_CLKS - 1);

  logic [TMR_W-1:0] timer;
  logic             longSel;

  // successive-error counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (stb.cntClr) begin
      errCount <= '0;
    end else if (stb.cntInc) begin
      errCount <= errCount + CNT_W'(1);
    end
  end

  // sticky iteration flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iterFlag <= 1'b0;
    end else if (stb.flagClr) begin
      iterFlag <= 1'b0;
    end else if (stb.flagSet) begin
      iterFlag <= 1'b1;
    end
  end

  // length select captured with the character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      longSel <= 1'b0;
    end else if (stb.latchLong) begin
      longSel <= nackLong;
    end
  end

  // shared down-counter for guard delay and pulse width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (stb.loadDelay) begin
      timer <= DELAY_LOAD;
    end else if (stb.loadLen) begin
      timer <= longSel ? LONG_LOAD : SHORT_LOAD;
    end else if (timer != '0) begin
      timer <= timer - TMR_W'(1);
    end
  end

  assign timerDone  = (timer == '0);
  assign cntAtLimit = (errCount >= maxIter);

endmodule

// File: rtl/t0nack_control.sv
module t0nack_control
  import t0nack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic       parityErr,
  input  logic       inhibitNack,
  input  logic       limitEn,
  input  logic       iterClr,
  input  logic       cntAtLimit,
  input  logic       timerDone,
  output dpStrobes_t stb,
  output logic       nackDrive,
  output logic       seqIdle
);

  seqState_e state, stateNext;
  logic      accept;
  logic      sendNack;

  assign seqIdle  = (state == SEQ_IDLE);
  assign accept   = charValid && seqIdle && !iterClr;
  assign sendNack = accept && parityErr && !inhibitNack && (!limitEn || !cntAtLimit);

  always_comb begin
    stb         = '0;
    stb.flagClr = iterClr;
    if (iterClr) begin
      stb.cntClr = 1'b1;
    end else if (accept) begin
      stb.latchLong = 1'b1;
      if (!limitEn || !parityErr) begin
        stb.cntClr = 1'b1;
      end else if (!cntAtLimit) begin
        stb.cntInc = 1'b1;
      end else begin
        stb.flagSet = 1'b1;
      end
    end

    stateNext = state;
    unique case (state)
      SEQ_IDLE: begin
        if (sendNack) begin
          stateNext     = SEQ_WAIT;
          stb.loadDelay = 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (timerDone) begin
          stateNext   = SEQ_DRIVE;
          stb.loadLen = 1'b1;
        end
      end
      SEQ_DRIVE: begin
        if (timerDone) begin
          stateNext = SEQ_IDLE;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign nackDrive = (state == SEQ_DRIVE);

endmodule

// File: rtl/t0_nack_ctrl.sv
module t0_nack_ctrl
  import t0nack_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int ETU_CLKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             parityErr,
  input  logic             inhibitNack,
  input  logic             limitEn,
  input  logic [CNT_W-1:0] maxIter,
  input  logic             nackLong,
  input  logic             iterClr,
  output logic             nackDrive,
  output logic             iterFlag,
  output logic [CNT_W-1:0] errCount
);

  dpStrobes_t stb;
  logic       cntAtLimit;
  logic       timerDone;
  logic       seqIdle;

  t0nack_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .charValid  (charValid),
    .parityErr  (parityErr),
    .inhibitNack(inhibitNack),
    .limitEn    (limitEn),
    .iterClr    (iterClr),
    .cntAtLimit (cntAtLimit),
    .timerDone  (timerDone),
    .stb        (stb),
    .nackDrive  (nackDrive),
    .seqIdle    (seqIdle)
  );

  t0nack_datapath #(
    .CNT_W   (CNT_W),
    .ETU_CLKS(ETU_CLKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .nackLong  (nackLong),
    .maxIter   (maxIter),
    .errCount  (errCount),
    .iterFlag  (iterFlag),
    .cntAtLimit(cntAtLimit),
    .timerDone (timerDone)
  );

endmodule

// File: rtl/t0_nack_ctrl_chk.sv
module t0_nack_ctrl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             charValid,
  input logic             parityErr,
  input logic             inhibitNack,
  input logic             limitEn,
  input logic [CNT_W-1:0] maxIter,
  input logic             iterClr,
  input logic             nackDrive,
  input logic             iterFlag,
  input logic [CNT_W-1:0] errCount,
  input logic             seqIdle
);

  logic accepted;
  assign accepted = charValid && seqIdle && !iterClr;

  AST_INHIBIT_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && inhibitNack) |=> seqIdle) else $error("AST_INHIBIT_NO_ARM"); // R1

  AST_OPEN_MODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !limitEn) |=> (errCount == '0)) else $error("AST_OPEN_MODE_ZERO"); // R2

  AST_LIMIT_WITHHOLD: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && limitEn && parityErr && (errCount >= maxIter))
      |=> (seqIdle && iterFlag && $stable(errCount))) else $error("AST_LIMIT_WITHHOLD"); // R4

  AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !parityErr) |=> (errCount == '0)) else $error("AST_GOOD_CLEARS"); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (iterFlag && !iterClr) |=> iterFlag) else $error("AST_FLAG_STICKY"); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    iterClr |=> (!iterFlag && errCount == '0)) else $error("AST_CLEAR_WINS"); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (!seqIdle && !iterClr) |=> $stable(errCount)) else $error("AST_BUSY_IGNORE"); // R8

  AST_DRIVE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    nackDrive |-> !seqIdle) else $error("AST_DRIVE_BUSY"); // R7

endmodule

bind t0_nack_ctrl t0_nack_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .charValid  (charValid),
  .parityErr  (parityErr),
  .inhibitNack(inhibitNack),
  .limitEn    (limitEn),
  .maxIter    (maxIter),
  .iterClr    (iterClr),
  .nackDrive  (nackDrive),
  .iterFlag   (iterFlag),
  .errCount   (errCount),
  .seqIdle    (seqIdle)
);

// File: tb/t0_nack_ctrl_tb_top.sv
module t0_nack_ctrl_tb_top;

  localparam int CNT_W    = 3;
  localparam int ETU_CLKS = 16;
  localparam int HALF     = ETU_CLKS / 2;
  localparam int WIN      = HALF + 2 * ETU_CLKS + 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             charValid = 1'b0;
  logic             parityErr = 1'b0;
  logic             inhibitNack = 1'b0;
  logic             limitEn = 1'b0;
  logic [CNT_W-1:0] maxIter = '0;
  logic             nackLong = 1'b0;
  logic             iterClr = 1'b0;
  logic             nackDrive;
  logic             iterFlag;
  logic [CNT_W-1:0] errCount;

  int testsRun = 0;
  int testsFailed = 0;
  int mCnt = 0;
  bit mFlag = 1'b0;

  always #4 clk = ~clk;

  t0_nack_ctrl #(.CNT_W(CNT_W), .ETU_CLKS(ETU_CLKS)) dut_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .parityErr(parityErr),
    .inhibitNack(inhibitNack), .limitEn(limitEn), .maxIter(maxIter),
    .nackLong(nackLong), .iterClr(iterClr), .nackDrive(nackDrive),
    .iterFlag(iterFlag), .errCount(errCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model: returns 1 when a NACK is due, updates mCnt/mFlag
  function automatic bit modelChar(input bit perr, input bit inh, input bit lim, input int mx);
    bit nack = 1'b0;
    if (!lim || !perr) begin
      mCnt = 0;
      nack = perr && !inh;
    end else if (mCnt < mx) begin
      mCnt = mCnt + 1;
      nack = !inh;
    end else begin
      mFlag = 1'b1;
    end
    return nack;
  endfunction

  function automatic int expWidth(input bit nack, input bit lng);
    if (!nack) return 0;
    return lng ? 2 * ETU_CLKS : ETU_CLKS;
  endfunction

  // observe one NACK window starting at the negedge after the sampling edge
  task automatic observe(output int firstIdx, output int highCnt);
    firstIdx = -1;
    highCnt  = 0;
    for (int i = 0; i < WIN; i++) begin
      if (nackDrive) begin
        if (firstIdx < 0) firstIdx = i;
        highCnt++;
      end
      @(negedge clk);
    end
  endtask

  task automatic sendChar(input bit perr, input bit lng, input string tag);
    int fi, hc, ew;
    bit en;
    en = modelChar(perr, inhibitNack, limitEn, int'(maxIter));
    ew = expWidth(en, lng);
    parityErr = perr;
    nackLong  = lng;
    charValid = 1'b1;
    @(negedge clk);
    charValid = 1'b0;
    nackLong  = ~lng;
    observe(fi, hc);
    chk({tag, " R7 nack width"}, hc, ew);
    chk({tag, " R7 nack start"}, fi, en ? HALF : -1);
    chk({tag, " R3 errCount"}, int'(errCount), mCnt);
    chk({tag, " R4 iterFlag"}, int'(iterFlag), int'(mFlag));
  endtask

  task automatic pulseClr();
    iterClr = 1'b1;
    @(negedge clk);
    iterClr = 1'b0;
    mCnt = 0;
    mFlag = 1'b0;
    chk("R6 clear flag", int'(iterFlag), 0);
    chk("R6 clear count", int'(errCount), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int fi, hc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 reset nackDrive", int'(nackDrive), 0);
    chk("R9 reset iterFlag", int'(iterFlag), 0);
    chk("R9 reset errCount", int'(errCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: open mode, errors always NACKed
    limitEn = 1'b0; inhibitNack = 1'b0;
    sendChar(1'b1, 1'b0, "R2 open err");
    sendChar(1'b1, 1'b1, "R2 open err long");
    sendChar(1'b0, 1'b0, "R2 open good");

    // R3/R4: limit 2
    limitEn = 1'b1; maxIter = 3'd2;
    sendChar(1'b1, 1'b0, "R3 first");
    sendChar(1'b1, 1'b1, "R3 second");
    sendChar(1'b1, 1'b0, "R4 past limit");
    chk("R4 flag set", int'(iterFlag), 1);
    sendChar(1'b0, 1'b0, "R5 good clears");
    chk("R5 flag kept", int'(iterFlag), 1);
    pulseClr();

    // R4: zero limit withholds first NACK
    maxIter = 3'd0;
    sendChar(1'b1, 1'b0, "R4 zero limit");
    chk("R4 zero limit flag", int'(iterFlag), 1);
    pulseClr();

    // R1: suppression in both modes
    inhibitNack = 1'b1; limitEn = 1'b0;
    sendChar(1'b1, 1'b0, "R1 open inhibit");
    limitEn = 1'b1; maxIter = 3'd3;
    sendChar(1'b1, 1'b0, "R1 limit inhibit");
    chk("R1 count still moves", int'(errCount), 1);
    inhibitNack = 1'b0;
    sendChar(1'b0, 1'b0, "R5 reset count");

    // R6: strobe colliding with clear is dropped
    parityErr = 1'b1; charValid = 1'b1; iterClr = 1'b1;
    @(negedge clk);
    charValid = 1'b0; iterClr = 1'b0;
    observe(fi, hc);
    chk("R6 collide no nack", hc, 0);
    chk("R6 collide count", int'(errCount), 0);

    // R8: strobe during pending NACK is ignored
    limitEn = 1'b1; maxIter = 3'd5; mCnt = 0;
    parityErr = 1'b1; nackLong = 1'b0; charValid = 1'b1;
    @(negedge clk);
    charValid = 1'b0;
    @(negedge clk);
    charValid = 1'b1;
    @(negedge clk);
    charValid = 1'b0;
    chk("R8 count after busy strobe", int'(errCount), 1);
    observe(fi, hc);
    chk("R8 single nack width", hc, ETU_CLKS);
    chk("R8 single nack start", fi, HALF - 2);
    chk("R8 count unchanged", int'(errCount), 1);
    mCnt = 1;

    // random mix
    for (int n = 0; n < 360; n++) begin
      if (n % 8 == 0) begin
        inhibitNack = ($urandom_range(0, 4) == 0);
        limitEn     = ($urandom_range(0, 2) != 0);
        maxIter     = CNT_W'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 24) == 0) pulseClr();
      sendChar($urandom_range(0, 9) < 6, 1'($urandom_range(0, 1)), "RND");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule